// File: doc/BRIEF.md
# Interrupt Source Trigger and Pending Front End

This block sits at the input side of a platform interrupt controller. It serves `NUM_SRC` wired sources numbered 1 to `NUM_SRC`. Number 0 is reserved and never exists. Each source holds a small configuration word that either picks a trigger mode or hands the source off to a child domain. For every source the block keeps the last sampled input level, a pending flag and an enable flag. It drives three vectors to the downstream priority and delivery logic: the rectified input, pending and enable.

Software drives the block through a single write-strobe port with word addresses. It can set or clear pending and enable flags in two ways: a 32-bit mask covering 32 sources, or the number of one source. A combinational read port returns configuration words and the word-wide vectors. The trigger mode controls how hardware sets pending. It also controls whether software pending commands are accepted. A configuration write can itself clear state or set pending.

Top module: `irq_src_gate`

## Requirements
- R1: The configuration word for source k sits at word address k. Bit 10 is the delegate flag. Bits 2:0 hold the mode: 0 off, 1 detached, 4 rising edge, 5 falling edge, 6 level high, 7 level low. A write of reserved mode 2 or 3 stores 0. For a non-delegated source, a read returns only the stored mode.
- R2: A write with bit 10 set stores bit 10 together with bits 9:0 (a child index), and the source counts as inactive. If `HAS_CHILD` is 0, such a write stores 0 instead.
- R3: The rectified input is the sampled input XOR an invert flag. The invert flag is 1 for modes 5 and 7. The rectified input is 0 for an off source or a delegated source.
- R4: In mode 4, a 0-to-1 input change sets pending on the next clock edge. In mode 5, a 1-to-0 change does the same. A detached source never sets pending from its input.
- R5: In mode 6, pending is set on every edge at which the input is high. In mode 7, it is set on every edge at which the input is low.
- R6: A software clear-pending command clears pending in modes 1, 4 and 5. It has no effect in modes 6 and 7.
- R7: A software set-pending command sets pending in modes 1, 4 and 5. In modes 6 and 7 it is ignored when `msi_mode` is 0. When `msi_mode` is 1, it is accepted only while the rectified input is 1.
- R8: A configuration write that stores 0 or sets the delegate flag clears both pending and enable. Any other configuration write sets pending when the new mode's rectified input is 1.
- R9: Set-enable and clear-enable commands leave the enable flag of an off or delegated source at 0.
- R10: Command addresses are as follows. Word-wide masks use set-pending 0x100+w, clear-pending 0x120+w, set-enable 0x140+w and clear-enable 0x160+w, where bit b of word w stands for source 32w+b. By-number commands use 0x180 set-pending, 0x181 clear-pending, 0x182 set-enable and 0x183 clear-enable. A source number of 0 or above `NUM_SRC` is ignored.
- R11: A write to 0x184 byte-swaps the 32-bit value and then acts as a set-pending-by-number command.
- R12: Reads return pending at 0x100+w, the rectified input at 0x120+w, enable at 0x140+w, and 0 at 0x160+w. Bit 0 of word 0 and bits above `NUM_SRC` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msi_mode | input | 1 | 1 when the domain delivers by message, 0 for direct delivery |
| src_in | input | NUM_SRC | Raw source levels, bit k is source k |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 32 | Combinational read data |
| rect_vec | output | NUM_SRC | Rectified inputs |
| pend_vec | output | NUM_SRC | Pending flags |
| en_vec | output | NUM_SRC | Enable flags |

## Verification
A wrong stored mode or a stale sampled input shows up on `rect_vec` in the same cycle. It shows up on `pend_vec` one edge after the input change that should have counted, or that should have been ignored. A missed kill on a configuration write leaves pending or enable high on the first sample after the write. A wrong bit mapping in the decoder moves the effect of a mask or number command to a neighbouring source, which the per-source vectors show at once. The bench sweeps every mode over an input pattern and compares each cycle against its own model of edges and levels.

// File: rtl/isg_pkg.sv
package isg_pkg;

  localparam int ISG_AW = 9;

  // Command and read map, word addresses
  localparam logic [ISG_AW-1:0] ISG_SETP_W  = 9'h100;
  localparam logic [ISG_AW-1:0] ISG_CLRP_W  = 9'h120;
  localparam logic [ISG_AW-1:0] ISG_SETE_W  = 9'h140;
  localparam logic [ISG_AW-1:0] ISG_CLRE_W  = 9'h160;
  localparam logic [ISG_AW-1:0] ISG_SETP_N  = 9'h180;
  localparam logic [ISG_AW-1:0] ISG_CLRP_N  = 9'h181;
  localparam logic [ISG_AW-1:0] ISG_SETE_N  = 9'h182;
  localparam logic [ISG_AW-1:0] ISG_CLRE_N  = 9'h183;
  localparam logic [ISG_AW-1:0] ISG_SETP_NS = 9'h184;

  localparam logic [2:0] M_OFF    = 3'd0;
  localparam logic [2:0] M_DETACH = 3'd1;
  localparam logic [2:0] M_RISE   = 3'd4;
  localparam logic [2:0] M_FALL   = 3'd5;
  localparam logic [2:0] M_HIGH   = 3'd6;
  localparam logic [2:0] M_LOW    = 3'd7;

  typedef struct packed {
    logic       deleg;
    logic [9:0] body;
  } isg_cfg_t;

  function automatic isg_cfg_t isg_clean_cfg(logic [10:0] d, bit has_child);
    isg_cfg_t c;
    c = '0;
    if (d[10]) begin
      if (has_child) c = {1'b1, d[9:0]};
    end else if (d[2:0] != 3'd2 && d[2:0] != 3'd3) begin
      c.body = {7'd0, d[2:0]};
    end
    return c;
  endfunction

  function automatic logic isg_active(isg_cfg_t c);
    return !c.deleg && (c.body[2:0] != M_OFF);
  endfunction

  function automatic logic isg_level(isg_cfg_t c);
    return !c.deleg && (c.body[2:0] == M_HIGH || c.body[2:0] == M_LOW);
  endfunction

  function automatic logic isg_rect(isg_cfg_t c, logic in_lvl);
    logic inv;
    inv = (c.body[2:0] == M_FALL) || (c.body[2:0] == M_LOW);
    return isg_active(c) && (in_lvl ^ inv);
  endfunction

  function automatic logic isg_hw_hit(isg_cfg_t c, logic raw, logic prev);
    logic hit;
    hit = 1'b0;
    if (!c.deleg) begin
      case (c.body[2:0])
        M_RISE:  hit = raw && !prev;
        M_FALL:  hit = !raw && prev;
        M_HIGH:  hit = raw;
        M_LOW:   hit = !raw;
        default: hit = 1'b0;
      endcase
    end
    return hit;
  endfunction

  function automatic logic [31:0] isg_bswap(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/isg_cmd_decode.sv
module isg_cmd_decode
  import isg_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ISG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NUM_SRC:1]  cfg_we,
  output logic [NUM_SRC:1]  set_p,
  output logic [NUM_SRC:1]  clr_p,
  output logic [NUM_SRC:1]  set_e,
  output logic [NUM_SRC:1]  clr_e
);

  logic [31:0] swapped;
  logic        num_cmd;

  assign swapped = isg_bswap(wr_data);
  assign num_cmd = wr_en && (wr_addr == ISG_SETP_N || wr_addr == ISG_SETP_NS);

  for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
    localparam int W = k / 32;
    localparam int B = k % 32;
    localparam logic [ISG_AW-1:0] A_CFG = ISG_AW'(k);
    localparam logic [31:0]       NUM   = 32'(k);

    assign cfg_we[k] = wr_en && (wr_addr == A_CFG);
    assign set_p[k]  = wr_en && (((wr_addr == ISG_SETP_W + ISG_AW'(W)) && wr_data[B]) ||
                                 ((wr_addr == ISG_SETP_N) && (wr_data == NUM)) ||
                                 ((wr_addr == ISG_SETP_NS) && (swapped == NUM)));
    assign clr_p[k]  = wr_en && (((wr_addr == ISG_CLRP_W + ISG_AW'(W)) && wr_data[B]) ||
                                 ((wr_addr == ISG_CLRP_N) && (wr_data == NUM)));
    assign set_e[k]  = wr_en && (((wr_addr == ISG_SETE_W + ISG_AW'(W)) && wr_data[B]) ||
                                 ((wr_addr == ISG_SETE_N) && (wr_data == NUM)));
    assign clr_e[k]  = wr_en && (((wr_addr == ISG_CLRE_W + ISG_AW'(W)) && wr_data[B]) ||
                                 ((wr_addr == ISG_CLRE_N) && (wr_data == NUM)));
  end

  // R10: a by-number command names at most one source
  p_num_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    num_cmd |-> $onehot0(set_p));

endmodule

// File: rtl/isg_src_cell.sv
module isg_src_cell
  import isg_pkg::*;
#(
  parameter bit HAS_CHILD = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msi_mode,
  input  logic       raw,
  input  logic       cfg_we,
  input  logic [10:0] cfg_wdata,
  input  logic       set_pend,
  input  logic       clr_pend,
  input  logic       set_en,
  input  logic       clr_en,
  output logic       rect,
  output logic       pend,
  output logic       en,
  output isg_cfg_t   cfg
);

  isg_cfg_t cfg_q, cfg_new;
  logic in_q, pend_q, en_q;

  // named internal events
  logic active, level, hw_hit, sw_set_ok, sw_clr_ok, kill, new_rect;

  always_comb begin
    cfg_new   = isg_clean_cfg(cfg_wdata, HAS_CHILD);
    kill      = !isg_active(cfg_new);
    new_rect  = isg_rect(cfg_new, in_q);
    active    = isg_active(cfg_q);
    level     = isg_level(cfg_q);
    hw_hit    = isg_hw_hit(cfg_q, raw, in_q);
    rect      = isg_rect(cfg_q, in_q);
    sw_set_ok = active && (!level || (msi_mode && rect));
    sw_clr_ok = active && !level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      in_q   <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      in_q <= raw;
      if (cfg_we) begin
        cfg_q  <= cfg_new;
        pend_q <= kill ? 1'b0 : (pend_q || hw_hit || new_rect);
        en_q   <= kill ? 1'b0 : en_q;
      end else begin
        pend_q <= (pend_q && !(clr_pend && sw_clr_ok)) || (set_pend && sw_set_ok) || hw_hit;
        en_q   <= (en_q && !(clr_en && active)) || (set_en && active);
      end
    end
  end

  assign pend = pend_q;
  assign en   = en_q;
  assign cfg  = cfg_q;

  // R8: a write that turns the source off or delegates it clears its state
  p_kill_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && kill) |=> (!pend_q && !en_q));

  // R9: an inactive source never holds enable or pending
  p_inactive_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!en_q && !pend_q));

  // R4: a rising edge in rising mode is caught on the next edge
  p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !cfg_q.deleg && cfg_q.body[2:0] == M_RISE && raw && !in_q) |=> pend_q);

  // R6: level sources keep pending against clear commands
  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && level && pend_q) |=> pend_q);

endmodule

// File: rtl/isg_read_mux.sv
module isg_read_mux
  import isg_pkg::*;
#(
  parameter int NUM_SRC = 40,
  localparam int NW     = NUM_SRC / 32 + 1,
  localparam int CW     = $bits(isg_cfg_t)
) (
  input  logic [ISG_AW-1:0]      rd_addr,
  input  logic [NUM_SRC:1]       rect_vec,
  input  logic [NUM_SRC:1]       pend_vec,
  input  logic [NUM_SRC:1]       en_vec,
  input  logic [NUM_SRC*CW-1:0]  cfg_flat,
  output logic [31:0]            rd_data
);

  logic [NW*32-1:0] p_pad, r_pad, e_pad;

  always_comb begin
    p_pad = '0;
    r_pad = '0;
    e_pad = '0;
    p_pad[NUM_SRC:1] = pend_vec;
    r_pad[NUM_SRC:1] = rect_vec;
    e_pad[NUM_SRC:1] = en_vec;
    rd_data = '0;
    for (int k = 1; k <= NUM_SRC; k++) begin
      if (rd_addr == ISG_AW'(k)) rd_data = {{(32-CW){1'b0}}, cfg_flat[(k-1)*CW +: CW]};
    end
    for (int w = 0; w < NW; w++) begin
      if (rd_addr == ISG_SETP_W + ISG_AW'(w)) rd_data = p_pad[w*32 +: 32];
      if (rd_addr == ISG_CLRP_W + ISG_AW'(w)) rd_data = r_pad[w*32 +: 32];
      if (rd_addr == ISG_SETE_W + ISG_AW'(w)) rd_data = e_pad[w*32 +: 32];
    end
  end

endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
  import isg_pkg::*;
#(
  parameter int NUM_SRC   = 40,
  parameter bit HAS_CHILD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_mode,
  input  logic [NUM_SRC:1]  src_in,
  input  logic              wr_en,
  input  logic [ISG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ISG_AW-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NUM_SRC:1]  rect_vec,
  output logic [NUM_SRC:1]  pend_vec,
  output logic [NUM_SRC:1]  en_vec
);

  localparam int CW = $bits(isg_cfg_t);

  logic [NUM_SRC:1] cfg_we, set_p, clr_p, set_e, clr_e;
  logic [NUM_SRC*CW-1:0] cfg_flat;

  isg_cmd_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_we  (cfg_we),
    .set_p   (set_p),
    .clr_p   (clr_p),
    .set_e   (set_e),
    .clr_e   (clr_e)
  );

  for (genvar k = 1; k <= NUM_SRC; k++) begin : g_cell
    isg_cfg_t cfg_k;
    isg_src_cell #(.HAS_CHILD(HAS_CHILD)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .msi_mode  (msi_mode),
      .raw       (src_in[k]),
      .cfg_we    (cfg_we[k]),
      .cfg_wdata (wr_data[10:0]),
      .set_pend  (set_p[k]),
      .clr_pend  (clr_p[k]),
      .set_en    (set_e[k]),
      .clr_en    (clr_e[k]),
      .rect      (rect_vec[k]),
      .pend      (pend_vec[k]),
      .en        (en_vec[k]),
      .cfg       (cfg_k)
    );
    assign cfg_flat[(k-1)*CW +: CW] = cfg_k;
  end

  isg_read_mux #(.NUM_SRC(NUM_SRC)) u_rd (
    .rd_addr  (rd_addr),
    .rect_vec (rect_vec),
    .pend_vec (pend_vec),
    .en_vec   (en_vec),
    .cfg_flat (cfg_flat),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/irq_src_gate_bench.sv
module irq_src_gate_bench;

  localparam int N  = 40;
  localparam int N2 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msi_mode = 1'b0;
  logic [N:1]  src_in = '0;
  logic [N2:1] src_in2 = '0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [8:0]  rd_addr = '0;
  logic [31:0] rd_data, rd_data2;
  logic [N:1]  rect_vec, pend_vec, en_vec;
  logic [N2:1] rect2, pend2, en2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_src_gate #(.NUM_SRC(N), .HAS_CHILD(1'b1)) u_irq_src_gate (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .src_in(src_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rect_vec(rect_vec), .pend_vec(pend_vec), .en_vec(en_vec));

  irq_src_gate #(.NUM_SRC(N2), .HAS_CHILD(1'b0)) u_irq_src_gate_nc (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .src_in(src_in2),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data2), .rect_vec(rect2), .pend_vec(pend2), .en_vec(en2));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic bit m_rect(int m, bit v);
    if (m == 0) return 1'b0;
    return v ^ ((m == 5) || (m == 7));
  endfunction

  function automatic bit m_hit(int m, bit v, bit p);
    case (m)
      4: return v && !p;
      5: return !v && p;
      6: return v;
      7: return !v;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [N:1] snap;
    int modes [5] = '{1, 4, 5, 6, 7};
    bit pat [6] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state
    check("R12 reset pend", 32'(pend_vec), 32'd0);
    check("R12 reset en", 32'(en_vec), 32'd0);
    check("R3 reset rect", 32'(rect_vec), 32'd0);
    rd(9'd1, d); check("R1 reset cfg", d, 32'd0);

    // R1: mode codes stored, reserved codes read 0
    for (int c = 0; c < 8; c++) begin
      wr(9'd3, 32'(c));
      rd(9'd3, d);
      check("R1 cfg readback", d, (c == 2 || c == 3) ? 32'd0 : 32'(c));
    end
    wr(9'd3, 32'd0);

    // R2: delegate stored with child, dropped without
    wr(9'd5, 32'h0000_0555);
    rd(9'd5, d); check("R2 delegate stored", d, 32'h555);
    #1 check("R2 no child stores zero", rd_data2, 32'd0);
    check("R3 delegated rect", 32'(rect_vec[5]), 32'd0);

    // R3 R4 R5 R6: sweep modes over an input pattern on source 7
    foreach (modes[mi]) begin
      int m;
      bit mp, prev;
      m = modes[mi];
      src_in[7] = 1'b0;
      wr(9'd7, 32'd0);
      wr(9'd7, 32'(m));
      mp = m_rect(m, 1'b0);
      prev = 1'b0;
      check("R8 config sets pending", 32'(pend_vec[7]), 32'(mp));
      foreach (pat[i]) begin
        bit v;
        v = pat[i];
        src_in[7] = v;
        tick();
        mp = mp | m_hit(m, v, prev);
        prev = v;
        check((m >= 6) ? "R5 level pending" : "R4 edge pending", 32'(pend_vec[7]), 32'(mp));
        check("R3 rectified", 32'(rect_vec[7]), 32'(m_rect(m, v)));
        wr(9'h181, 32'd7);
        if (m < 6) mp = 1'b0;
        else       mp = mp | m_rect(m, v);
        check("R6 clear pending", 32'(pend_vec[7]), 32'(mp));
      end
    end

    // R7: set pending rules
    wr(9'd9, 32'd6);
    wr(9'h180, 32'd9);
    check("R7 level direct ignored", 32'(pend_vec[9]), 32'd0);
    msi_mode = 1'b1;
    wr(9'h180, 32'd9);
    check("R7 level msi rect low ignored", 32'(pend_vec[9]), 32'd0);
    msi_mode = 1'b0;
    wr(9'd10, 32'd4);
    wr(9'h180, 32'd10);
    check("R7 edge set", 32'(pend_vec[10]), 32'd1);
    wr(9'd11, 32'd1);
    wr(9'h100, 32'(1) << 11);
    check("R7 detached word set", 32'(pend_vec[11]), 32'd1);
    wr(9'h120, 32'(1) << 11);
    check("R6 detached word clear", 32'(pend_vec[11]), 32'd0);

    // R8: configuration write side effects
    src_in[12] = 1'b1;
    tick();
    wr(9'd12, 32'd4);
    check("R8 rect high sets pending", 32'(pend_vec[12]), 32'd1);
    wr(9'h182, 32'd12);
    check("R8 enable set", 32'(en_vec[12]), 32'd1);
    wr(9'd12, 32'd0);
    check("R8 zero write clears", {30'd0, pend_vec[12], en_vec[12]}, 32'd0);
    wr(9'd12, 32'd4);
    wr(9'h182, 32'd12);
    wr(9'd12, 32'h403);
    check("R8 delegate write clears", {30'd0, pend_vec[12], en_vec[12]}, 32'd0);

    // R9: enable commands
    wr(9'h182, 32'd13);
    check("R9 inactive enable ignored", 32'(en_vec[13]), 32'd0);
    wr(9'd13, 32'd5);
    wr(9'h140, 32'(1) << 13);
    check("R9 word enable", 32'(en_vec[13]), 32'd1);
    wr(9'h160, 32'(1) << 13);
    check("R9 word disable", 32'(en_vec[13]), 32'd0);
    wr(9'h182, 32'd5);
    check("R9 delegated enable ignored", 32'(en_vec[5]), 32'd0);

    // R10 R11: numbers out of range, high word, byte swap
    snap = pend_vec;
    wr(9'h180, 32'd0);
    check("R10 number zero ignored", 32'(pend_vec ^ snap), 32'd0);
    check("R10 number zero upper", 32'((pend_vec ^ snap) >> 32), 32'd0);
    wr(9'h180, 32'd41);
    check("R10 out of range ignored", 32'(pend_vec ^ snap), 32'd0);
    wr(9'd40, 32'd4);
    wr(9'h180, 32'd40);
    check("R10 high source number", 32'(pend_vec[40]), 32'd1);
    wr(9'd14, 32'd4);
    wr(9'h184, 32'h0E00_0000);
    check("R11 byte-swapped number", 32'(pend_vec[14]), 32'd1);
    wr(9'h183, 32'd13);
    wr(9'h182, 32'd14);

    // R12: word reads
    rd(9'h100, d); check("R12 pending word 0", d, {pend_vec[31:1], 1'b0});
    rd(9'h101, d); check("R12 pending word 1", d, {23'd0, pend_vec[40:32]});
    rd(9'h120, d); check("R12 rect word 0", d, {rect_vec[31:1], 1'b0});
    rd(9'h140, d); check("R12 enable word 0", d, {en_vec[31:1], 1'b0});
    rd(9'h160, d); check("R12 clear-enable reads zero", d, 32'd0);
    rd(9'h102, d); check("R12 word beyond range", d, 32'd0);
    check("R12 pending 14 seen", 32'(d[0] | pend_vec[14]), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule